// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block forms the 12-bit byte address used by an 8-bit core to reach its 4096-byte register file. It also holds the storage behind that address. The space is split into sixteen 256-byte banks. An instruction names a location in one of three ways:

- **Banked direct:** a 4-bit bank register is joined to the 8-bit operand.
- **Access window:** the same operand always reaches the low half of bank 0 or the high half of bank 15, whatever bank is selected.
- **Indirect:** a 16-bit pointer register supplies the address.

Three I/O registers are decoded inside the space and answer in place of the plain storage: port A data, port B data and port B direction. Reads are combinational from the current address. Writes to storage, to the port registers, to the bank register and to the pointer register all land on the rising clock edge.

Top module: `dmau_top`

## Requirements
- R1: With `ind_i`=0 and `banked_i`=1, `addr_o` equals {bank register, `op_i`}.
- R2: With `ind_i`=0, `banked_i`=0 and `op_i` in 00h..7Fh, `addr_o` equals `op_i` (000h..07Fh) whatever the bank register holds.
- R3: With `ind_i`=0, `banked_i`=0 and `op_i` in 80h..FFh, `addr_o` equals F00h + `op_i` (F80h..FFFh) whatever the bank register holds.
- R4: With `ind_i`=1, `addr_o` equals bits [11:0] of the pointer register, and its bits [15:12] have no effect.
- R5: After reset the bank register and the pointer register are 0, port A and the port B latch are 00h, and the port B direction register is FFh (all inputs).
- R6: With `mem_we_i`=1, `wdata_i` is stored at `addr_o` on the rising edge. `rdata_o` shows the byte at `addr_o` combinationally, so one location gives the same byte through every mode that reaches it.
- R7: Address F80h is the port A data register. A write to it appears on `porta_o` after the edge, and a read of F80h returns it.
- R8: Address F81h is the port B latch and F93h is the port B direction register, where a bit value of 1 means input. `portb_o` shows the latch, and `portb_oe_o` is the inverse of the direction register. A read of F81h returns `portb_pins_i` on input bits and the latch on output bits. A read of F93h returns the direction register.
- R9: `bsr_we_i` loads `bsr_wd_i`, and `ptr_we_i` loads `ptr_wd_i`, on the rising edge. An address formed in the same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 8 | Instruction operand |
| banked_i | input | 1 | Direct form select: 1 banked, 0 access window |
| ind_i | input | 1 | 1 selects indirect addressing |
| bsr_we_i | input | 1 | Bank register write enable |
| bsr_wd_i | input | 4 | Bank register write data |
| ptr_we_i | input | 1 | Pointer register write enable |
| ptr_wd_i | input | 16 | Pointer register write data |
| mem_we_i | input | 1 | Data write enable at the current address |
| wdata_i | input | 8 | Data write byte |
| rdata_o | output | 8 | Byte read at the current address |
| addr_o | output | 12 | Computed data address |
| portb_pins_i | input | 8 | Sampled port B pin levels |
| porta_o | output | 8 | Port A data register |
| portb_o | output | 8 | Port B output latch |
| portb_oe_o | output | 8 | Port B per-bit output enable |

## Verification
The assertions assume that the mode inputs and the operand are settled before each rising edge. They also assume that a write to the bank or pointer register is judged only on the following cycle, and that nothing is checked until the internal reset has been released. The bench changes every input at the falling edge, and it samples outputs just after that. It compares addresses and read data only where its own model knows the stored byte, so locations that were never written are never judged.

// File: rtl/dmau_pkg.sv
`timescale 1ns/1ps
package dmau_pkg;
  typedef enum logic [1:0] {
    MODE_ACCESS   = 2'd0,
    MODE_BANKED   = 2'd1,
    MODE_INDIRECT = 2'd2
  } dmau_mode_e;

  function automatic dmau_mode_e dmau_decode(input logic ind, input logic banked);
    if (ind)         return MODE_INDIRECT;
    else if (banked) return MODE_BANKED;
    else             return MODE_ACCESS;
  endfunction
endpackage

// File: rtl/dmau_addr_gen.sv
`timescale 1ns/1ps
module dmau_addr_gen import dmau_pkg::*; #(
  parameter int OP_W   = 8,
  parameter int BANK_W = 4,
  parameter int PTR_W  = 16,
  localparam int AW    = OP_W + BANK_W
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              banked_i,
  input  logic              ind_i,
  input  logic [BANK_W-1:0] bsr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [AW-1:0]     addr_o
);
  dmau_mode_e mode;
  logic [AW-1:0] access_addr;
  logic          unused_ptr_hi;

  assign unused_ptr_hi = ^ptr_i[PTR_W-1:AW];
  assign mode          = dmau_decode(ind_i, banked_i);

  always_comb begin
    if (op_i[OP_W-1]) access_addr = {{BANK_W{1'b1}}, op_i};
    else              access_addr = {{BANK_W{1'b0}}, op_i};
  end

  always_comb begin
    unique case (mode)
      MODE_BANKED:   addr_o = {bsr_i, op_i};
      MODE_INDIRECT: addr_o = ptr_i[AW-1:0];
      default:       addr_o = access_addr;
    endcase
  end
endmodule

// File: rtl/dmau_ptr_regs.sv
`timescale 1ns/1ps
module dmau_ptr_regs #(
  parameter int BANK_W = 4,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsr_we_i,
  input  logic [BANK_W-1:0] bsr_wd_i,
  input  logic              ptr_we_i,
  input  logic [PTR_W-1:0]  ptr_wd_i,
  output logic [BANK_W-1:0] bsr_q,
  output logic [PTR_W-1:0]  ptr_q
);
  logic [BANK_W-1:0] bsr_d;
  logic [PTR_W-1:0]  ptr_d;

  always_comb begin
    bsr_d = bsr_q;
    ptr_d = ptr_q;
    if (bsr_we_i) bsr_d = bsr_wd_i;
    if (ptr_we_i) ptr_d = ptr_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsr_q <= '0;
      ptr_q <= '0;
    end else begin
      bsr_q <= bsr_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/dmau_port_regs.sv
`timescale 1ns/1ps
module dmau_port_regs #(
  parameter int          AW         = 12,
  parameter int          DW         = 8,
  parameter logic [11:0] PA_ADDR    = 12'hF80,
  parameter logic [11:0] PB_ADDR    = 12'hF81,
  parameter logic [11:0] PBDIR_ADDR = 12'hF93
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pins_i,
  output logic          hit_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] porta_o,
  output logic [DW-1:0] portb_o,
  output logic [DW-1:0] portb_oe_o
);
  logic sel_pa, sel_pb, sel_dir;
  logic [DW-1:0] pa_q, pa_d, pb_q, pb_d, dir_q, dir_d;

  assign sel_pa  = (addr_i == PA_ADDR[AW-1:0]);
  assign sel_pb  = (addr_i == PB_ADDR[AW-1:0]);
  assign sel_dir = (addr_i == PBDIR_ADDR[AW-1:0]);
  assign hit_o   = sel_pa | sel_pb | sel_dir;

  always_comb begin
    pa_d  = pa_q;
    pb_d  = pb_q;
    dir_d = dir_q;
    if (we_i && sel_pa)  pa_d  = wdata_i;
    if (we_i && sel_pb)  pb_d  = wdata_i;
    if (we_i && sel_dir) dir_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      pb_q  <= '0;
      dir_q <= '1;
    end else begin
      pa_q  <= pa_d;
      pb_q  <= pb_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_pa)  rdata_o = pa_q;
    if (sel_pb)  rdata_o = (dir_q & pins_i) | (~dir_q & pb_q);
    if (sel_dir) rdata_o = dir_q;
  end

  assign porta_o    = pa_q;
  assign portb_o    = pb_q;
  assign portb_oe_o = ~dir_q;
endmodule

// File: rtl/dmau_file.sv
`timescale 1ns/1ps
module dmau_file #(
  parameter int  AW    = 12,
  parameter int  DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/dmau_top.sv
`timescale 1ns/1ps
module dmau_top #(
  parameter int  OP_W   = 8,
  parameter int  BANK_W = 4,
  parameter int  PTR_W  = 16,
  parameter int  DW     = 8,
  localparam int AW     = OP_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic              banked_i,
  input  logic              ind_i,
  input  logic              bsr_we_i,
  input  logic [BANK_W-1:0] bsr_wd_i,
  input  logic              ptr_we_i,
  input  logic [PTR_W-1:0]  ptr_wd_i,
  input  logic              mem_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [AW-1:0]     addr_o,
  input  logic [DW-1:0]     portb_pins_i,
  output logic [DW-1:0]     porta_o,
  output logic [DW-1:0]     portb_o,
  output logic [DW-1:0]     portb_oe_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [BANK_W-1:0] bsr_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              port_hit;
  logic [DW-1:0]     port_rd, file_rd;
  logic              file_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dmau_ptr_regs #(.BANK_W(BANK_W), .PTR_W(PTR_W)) i_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bsr_we_i(bsr_we_i), .bsr_wd_i(bsr_wd_i),
    .ptr_we_i(ptr_we_i), .ptr_wd_i(ptr_wd_i),
    .bsr_q(bsr_q), .ptr_q(ptr_q)
  );

  dmau_addr_gen #(.OP_W(OP_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) i_agen (
    .op_i(op_i), .banked_i(banked_i), .ind_i(ind_i),
    .bsr_i(bsr_q), .ptr_i(ptr_q), .addr_o(addr_o)
  );

  dmau_port_regs #(.AW(AW), .DW(DW)) i_ports (
    .clk(clk), .rst_n(rst_n_s), .addr_i(addr_o), .we_i(mem_we_i),
    .wdata_i(wdata_i), .pins_i(portb_pins_i), .hit_o(port_hit),
    .rdata_o(port_rd), .porta_o(porta_o), .portb_o(portb_o),
    .portb_oe_o(portb_oe_o)
  );

  assign file_we = mem_we_i & ~port_hit;

  dmau_file #(.AW(AW), .DW(DW)) i_file (
    .clk(clk), .we_i(file_we), .addr_i(addr_o),
    .wdata_i(wdata_i), .rdata_o(file_rd)
  );

  assign rdata_o = port_hit ? port_rd : file_rd;
endmodule

// File: rtl/dmau_chk.sv
`timescale 1ns/1ps
module dmau_chk (
  input logic        clk,
  input logic        rst_n_s,
  input logic [7:0]  op_i,
  input logic        banked_i,
  input logic        ind_i,
  input logic        bsr_we_i,
  input logic [3:0]  bsr_wd_i,
  input logic        ptr_we_i,
  input logic [15:0] ptr_wd_i,
  input logic        mem_we_i,
  input logic [7:0]  wdata_i,
  input logic [11:0] addr_o,
  input logic [3:0]  bsr_q,
  input logic [15:0] ptr_q,
  input logic [7:0]  porta_o
);
  AST_BANKED_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ind_i && banked_i) |-> (addr_o[11:8] == bsr_q && addr_o[7:0] == op_i)); // R1
  AST_ACCESS_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ind_i && !banked_i && !op_i[7]) |-> (addr_o[11:7] == 5'h00)); // R2
  AST_ACCESS_HIGH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ind_i && !banked_i && op_i[7]) |-> (addr_o[11:7] == 5'h1F)); // R3
  AST_POINTER_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n_s)
    ind_i |-> (addr_o == ptr_q[11:0])); // R4
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    bsr_we_i |=> (bsr_q == $past(bsr_wd_i))); // R9
  AST_POINTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n_s)
    ptr_we_i |=> (ptr_q == $past(ptr_wd_i))); // R9
  AST_PORTA_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we_i && addr_o == 12'hF80) |=> (porta_o == $past(wdata_i))); // R7
endmodule

bind dmau_top dmau_chk i_chk (
  .clk(clk), .rst_n_s(rst_n_s), .op_i(op_i), .banked_i(banked_i), .ind_i(ind_i),
  .bsr_we_i(bsr_we_i), .bsr_wd_i(bsr_wd_i), .ptr_we_i(ptr_we_i), .ptr_wd_i(ptr_wd_i),
  .mem_we_i(mem_we_i), .wdata_i(wdata_i), .addr_o(addr_o), .bsr_q(bsr_q),
  .ptr_q(ptr_q), .porta_o(porta_o)
);

// File: tb/test_dmau_top.sv
`timescale 1ns/1ps
module test_dmau_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  op;
  logic        banked, ind, bsr_we, ptr_we, mem_we;
  logic [3:0]  bsr_wd;
  logic [15:0] ptr_wd;
  logic [7:0]  wdata, pins;
  logic [7:0]  rdata, porta, portb, portb_oe;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_bsr, m_ptr, m_pa, m_pb, m_dir;
  byte unsigned m_mem [int];

  always #2.5 clk = ~clk;

  dmau_top i_dmau_top (
    .clk(clk), .rst_n(rst_n), .op_i(op), .banked_i(banked), .ind_i(ind),
    .bsr_we_i(bsr_we), .bsr_wd_i(bsr_wd), .ptr_we_i(ptr_we), .ptr_wd_i(ptr_wd),
    .mem_we_i(mem_we), .wdata_i(wdata), .rdata_o(rdata), .addr_o(addr),
    .portb_pins_i(pins), .porta_o(porta), .portb_o(portb), .portb_oe_o(portb_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_addr();
    if (ind)         return m_ptr & 12'hFFF;
    else if (banked) return (m_bsr << 8) | op;
    else if (op[7])  return 12'hF00 | op;
    else             return op;
  endfunction

  // returns -1 when the model does not know the byte
  function automatic int model_read(input int a);
    if (a == 12'hF80) return m_pa;
    if (a == 12'hF81) return ((m_dir & pins) | (~m_dir & m_pb)) & 8'hFF;
    if (a == 12'hF93) return m_dir;
    if (m_mem.exists(a)) return m_mem[a];
    return -1;
  endfunction

  // one cycle: drive at falling edge, compare, then advance the model at the rising edge
  task automatic cyc(input logic [7:0] o, input logic b, input logic i,
                     input logic mwe, input logic [7:0] wd,
                     input logic bwe, input logic [3:0] bwd,
                     input logic pwe, input logic [15:0] pwd, input string req);
    int ea, er;
    @(negedge clk);
    op = o; banked = b; ind = i; mem_we = mwe; wdata = wd;
    bsr_we = bwe; bsr_wd = bwd; ptr_we = pwe; ptr_wd = pwd;
    #1;
    ea = model_addr();
    check(addr == 12'(ea), req, addr, ea);
    er = model_read(ea);
    if (er >= 0) check(rdata == 8'(er), req, rdata, er);
    @(posedge clk);
    if (mwe) begin
      if (ea == 12'hF80) m_pa = wd;
      else if (ea == 12'hF81) m_pb = wd;
      else if (ea == 12'hF93) m_dir = wd;
      else m_mem[ea] = wd;
    end
    if (bwe) m_bsr = bwd;
    if (pwe) m_ptr = pwd;
  endtask

  task automatic idle_port_check(input string req);
    @(negedge clk); #1;
    check(porta == 8'(m_pa), req, porta, m_pa);
    check(portb == 8'(m_pb), req, portb, m_pb);
    check(portb_oe == 8'(~m_dir), req, portb_oe, (~m_dir) & 8'hFF);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_bsr = 0; m_ptr = 0; m_pa = 0; m_pb = 0; m_dir = 8'hFF;
    op = 0; banked = 1; ind = 0; mem_we = 0; wdata = 0;
    bsr_we = 0; bsr_wd = 0; ptr_we = 0; ptr_wd = 0; pins = 8'h55;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R5 reset state: bank 0, pointer 0, ports cleared, direction all inputs
    cyc(8'h34, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(8'h00, 0, 1, 0, 0, 0, 0, 0, 0, "R5");
    idle_port_check("R5");

    // R9 bank load, R1 banked write at 345h
    cyc(8'h00, 1, 0, 0, 0, 1, 4'h3, 0, 0, "R9");
    cyc(8'h45, 1, 0, 1, 8'hA5, 0, 0, 0, 0, "R1");
    cyc(8'h45, 1, 0, 0, 0, 0, 0, 1, 16'hF345, "R6");
    // R4 indirect with upper pointer bits set reaches the same byte
    cyc(8'h00, 0, 1, 0, 0, 0, 0, 0, 0, "R4");

    // R2 access low window with bank 3 selected writes 010h
    cyc(8'h10, 0, 0, 1, 8'h3C, 0, 0, 1, 16'h0010, "R2");
    cyc(8'h10, 0, 1, 0, 0, 1, 4'h0, 0, 0, "R6");
    cyc(8'h10, 1, 0, 0, 0, 0, 0, 0, 0, "R6");

    // R3 access high window with bank 0 selected reaches port A at F80h
    cyc(8'h80, 0, 0, 1, 8'h96, 0, 0, 0, 0, "R3");
    idle_port_check("R7");
    cyc(8'h80, 1, 0, 0, 0, 1, 4'hF, 1, 16'h0F80, "R7");
    cyc(8'h80, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(8'h00, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
    cyc(8'hFF, 0, 0, 1, 8'h77, 1, 4'h2, 0, 0, "R3");
    cyc(8'hFF, 1, 0, 0, 0, 1, 4'hF, 0, 0, "R3");

    // R8 port B: low nibble inputs, latch AAh, pins 55h reads A5h
    cyc(8'h93, 0, 0, 1, 8'h0F, 0, 0, 0, 0, "R8");
    cyc(8'h81, 0, 0, 1, 8'hAA, 0, 0, 0, 0, "R8");
    cyc(8'h81, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    idle_port_check("R8");
    pins = 8'hF0;
    cyc(8'h81, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(8'h93, 1, 0, 0, 0, 0, 0, 0, 0, "R8");

    // mixed sweep: every mode, writes and register loads interleaved
    for (int k = 0; k < 400; k++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 2));
      cyc(8'($urandom), md == 2'd1, md == 2'd2, 1'($urandom),
          8'($urandom), ($urandom % 5) == 0, 4'($urandom),
          ($urandom % 5) == 0, 16'($urandom), "R6");
      if (k % 50 == 0) idle_port_check("R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule